// File: doc/BRIEF.md
# SRAM Bus Write-Cycle Controller

This block turns the loosely timed control lines of an asynchronous static-RAM style bus into clean read and write operations on a synchronous memory array. The bus has an active-low write strobe, one active-low and one active-high chip select, and an active-low output enable. It also carries an address, write data in, and read data out with its own drive-enable. Every control, address and data input is taken through a two-flop synchronizer. Cycle boundaries are then found from edges on the synchronized values.

A write is open only while all three write conditions hold together. The address is captured when the write opens, and the data is the last value seen before the write closes. The array is updated once, at the close. A read drives the data bus from the array one cycle after the synchronized read condition. The write strobe always wins over output enable. A lock input, meant for a power-fail supervisor, blocks all access. A programmable recovery window between bus cycles is enforced, and any cycle that arrives too early is flagged and rejected.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A write can only occur while `sram_we_n`=0, `sram_cs_n`=0 and `sram_cs`=1 at the same time. If any one of these is missing for the whole attempt, the array is not changed.
- R2: The write address is the value of `sram_addr` when the last of the three write conditions becomes true. Address changes later in the same write are ignored.
- R3: A write closes when the first of the three conditions goes false (`sram_we_n` rising, `sram_cs_n` rising or `sram_cs` falling). The array is updated exactly at that close.
- R4: The data stored is the value of `sram_wdata` sampled in the last cycle before the close. Earlier values in the same write are discarded.
- R5: While a read is driving the bus, pulling `sram_we_n` low turns `sram_rdata_oe` off within 3 clock cycles, even though output enable stays low.
- R6: With `sram_cs_n`=0, `sram_cs`=1, `sram_oe_n`=0 and `sram_we_n`=1 held for at least 3 cycles, `sram_rdata_oe`=1 and `sram_rdata` equals the array word at `sram_addr`.
- R7: While `pf_protect`=1, `sram_rdata_oe` stays 0 and no write changes the array. A write during which `pf_protect` rises is dropped.
- R8: A bus cycle begins when chip select is active together with either the write strobe or output enable. A cycle whose start follows the previous cycle's end by RECOVER or fewer idle cycles produces a one-cycle pulse on `cycle_err`. Such a cycle neither writes nor drives the bus. With RECOVER+1 or more idle cycles there is no pulse and no rejection.
- R9: After reset, `sram_rdata_oe`=0 and `cycle_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sram_we_n | input | 1 | Write strobe, active low |
| sram_cs_n | input | 1 | Chip select, active low |
| sram_cs | input | 1 | Chip select, active high |
| sram_oe_n | input | 1 | Output enable, active low |
| sram_addr | input | AW | Word address |
| sram_wdata | input | DW | Write data from the bus |
| sram_rdata | output | DW | Read data to the bus |
| sram_rdata_oe | output | 1 | Drive enable for read data |
| pf_protect | input | 1 | Access lock from the power supervisor |
| cycle_err | output | 1 | One-cycle pulse on a cycle started inside the recovery window |

## Verification
Two pairs of events are made to meet in the same cycles.

- **Lock and write close.** The lock can rise during an open write, so the write close and the lock decision meet. The bench raises the lock in the middle of a write and lets the write close while the lock is held. It then releases the lock and reads the word back. The old value must remain.
- **Read drive and write strobe.** The write strobe can fall while a read is driving the bus. The bench checks that the drive-enable drops and that the write then lands when the strobe returns high.

The recovery window is probed at exactly RECOVER and RECOVER+1 idle cycles.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef struct packed {
        logic wr_n;   // write strobe, low active
        logic csl_n;  // low-active select
        logic csh;    // high-active select
        logic rd_n;   // output enable, low active
        logic lock;   // power-fail lock
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{wr_n: 1'b1, csl_n: 1'b1, csh: 1'b0, rd_n: 1'b1, lock: 1'b0};

    function automatic logic is_sel(ctl_t c);
        return !c.csl_n && c.csh;
    endfunction

    function automatic logic is_write(ctl_t c);
        return is_sel(c) && !c.wr_n;
    endfunction

    function automatic logic is_read(ctl_t c);
        return is_sel(c) && c.wr_n && !c.rd_n;
    endfunction

    function automatic logic is_access(ctl_t c);
        return is_sel(c) && (!c.wr_n || !c.rd_n);
    endfunction

endpackage

// File: rtl/sramc_sync.sv
module sramc_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sramc_cycle_fsm.sv
module sramc_cycle_fsm
    import sramc_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 8,
    parameter int RECOVER = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] din_s,
    output logic          cmt_en,
    output logic [AW-1:0] cmt_addr,
    output logic [DW-1:0] cmt_data,
    output logic          rd_en,
    output logic          w_act,
    output logic          cycle_err
);
    localparam int CW = $clog2(RECOVER + 1);

    logic          w_now, acc_now, rd_now;
    logic          w_prev, acc_prev;
    logic          w_start, w_end, acc_start, acc_end;
    logic          early, rej, rej_now, abort;
    logic [CW-1:0] rec_cnt;
    logic [AW-1:0] addr_lat;
    logic [DW-1:0] data_hold;

    assign w_now     = is_write(ctl);
    assign rd_now    = is_read(ctl);
    assign acc_now   = is_access(ctl);
    assign w_start   = w_now && !w_prev;
    assign w_end     = !w_now && w_prev;
    assign acc_start = acc_now && !acc_prev;
    assign acc_end   = !acc_now && acc_prev;
    assign early     = acc_start && (rec_cnt != '0);
    assign rej_now   = rej || early;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_prev    <= 1'b0;
            acc_prev  <= 1'b0;
            rec_cnt   <= '0;
            rej       <= 1'b0;
            abort     <= 1'b0;
            cycle_err <= 1'b0;
            addr_lat  <= '0;
            data_hold <= '0;
        end else begin
            w_prev    <= w_now;
            acc_prev  <= acc_now;
            cycle_err <= early;
            if (acc_end)
                rec_cnt <= CW'(RECOVER);
            else if (rec_cnt != '0)
                rec_cnt <= rec_cnt - CW'(1);
            if (acc_end)
                rej <= 1'b0;
            else if (early)
                rej <= 1'b1;
            if (w_start)
                addr_lat <= addr_s;
            if (w_now)
                data_hold <= din_s;
            if (w_start)
                abort <= ctl.lock;
            else if (w_now && ctl.lock)
                abort <= 1'b1;
        end
    end

    assign cmt_en   = w_end && !abort && !rej && !ctl.lock;
    assign cmt_addr = addr_lat;
    assign cmt_data = data_hold;
    assign rd_en    = rd_now && !ctl.lock && !rej_now;
    assign w_act    = w_now;

    // address held for the whole open write
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (w_prev && $past(w_prev)) |-> $stable(addr_lat));

    // an early-start flag never lasts two cycles
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cycle_err |=> !cycle_err);
endmodule

// File: rtl/sramc_array.sv
module sramc_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= re;
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sramc_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 8,
    parameter int RECOVER = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sram_we_n,
    input  logic          sram_cs_n,
    input  logic          sram_cs,
    input  logic          sram_oe_n,
    input  logic [AW-1:0] sram_addr,
    input  logic [DW-1:0] sram_wdata,
    output logic [DW-1:0] sram_rdata,
    output logic          sram_rdata_oe,
    input  logic          pf_protect,
    output logic          cycle_err
);
    localparam int BW = AW + DW;

    ctl_t          ctl_raw, ctl_s;
    logic [BW-1:0] bus_s;
    logic          cmt_en, rd_en, w_act;
    logic [AW-1:0] cmt_addr;
    logic [DW-1:0] cmt_data;

    assign ctl_raw = '{wr_n: sram_we_n, csl_n: sram_cs_n, csh: sram_cs,
                       rd_n: sram_oe_n, lock: pf_protect};

    sramc_sync #(.W($bits(ctl_t)), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk (clk), .rst (rst), .d (ctl_raw), .q (ctl_s)
    );

    sramc_sync #(.W(BW), .RST_VAL('0)) u_bus_sync (
        .clk (clk), .rst (rst), .d ({sram_addr, sram_wdata}), .q (bus_s)
    );

    sramc_cycle_fsm #(.AW(AW), .DW(DW), .RECOVER(RECOVER)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_s),
        .addr_s    (bus_s[BW-1:DW]),
        .din_s     (bus_s[DW-1:0]),
        .cmt_en    (cmt_en),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data),
        .rd_en     (rd_en),
        .w_act     (w_act),
        .cycle_err (cycle_err)
    );

    sramc_array #(.AW(AW), .DW(DW)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (cmt_en),
        .waddr  (cmt_addr),
        .wdata  (cmt_data),
        .re     (rd_en),
        .raddr  (bus_s[BW-1:DW]),
        .rdata  (sram_rdata),
        .rvalid (sram_rdata_oe)
    );

    // write strobe wins over output enable
    assert_strobe_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $past(w_act) |-> !sram_rdata_oe);

    // lock keeps the bus undriven
    assert_lock_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_s.lock) |-> !sram_rdata_oe);

    // lock forbids any array update
    assert_lock_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_s.lock |-> !cmt_en);

    // a rejected cycle does not drive the bus
    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cycle_err |-> !sram_rdata_oe);
endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int REC = 4;
    localparam int GAP = REC + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we_n = 1'b1, cs_n = 1'b1, cs = 1'b0, oe_n = 1'b1, prot = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe, cyc_err;

    int n_chk = 0, n_fail = 0, err_total = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [1 << AW];
    bit            ref_ok  [1 << AW];

    always #2 clk = ~clk;

    sram_cycle_ctrl #(.AW(AW), .DW(DW), .RECOVER(REC)) dut (
        .clk (clk), .rst (rst), .sram_we_n (we_n), .sram_cs_n (cs_n), .sram_cs (cs),
        .sram_oe_n (oe_n), .sram_addr (addr), .sram_wdata (wdata), .sram_rdata (rdata),
        .sram_rdata_oe (rdata_oe), .pf_protect (prot), .cycle_err (cyc_err)
    );

    always @(posedge clk) if (!rst && cyc_err) err_total++;

    function automatic bit err_expected(int gap);
        return gap <= REC;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        we_n = 1'b1; cs_n = 1'b1; cs = 1'b0; oe_n = 1'b1;
    endtask

    // mode: 0 strobe ends, 1 low select ends, 2 high select ends
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int mode, input int gap);
        addr = a; wdata = d; we_n = 1'b0; cs_n = 1'b0; cs = 1'b1;
        repeat (5) @(negedge clk);
        case (mode)
            0: we_n = 1'b1;
            1: cs_n = 1'b1;
            default: cs = 1'b0;
        endcase
        @(negedge clk);
        go_idle();
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int gap,
                           output logic [DW-1:0] q, output logic en);
        addr = a; we_n = 1'b1; cs_n = 1'b0; cs = 1'b1; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        q = rdata; en = rdata_oe;
        go_idle();
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr_model(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int mode);
        do_write(a, d, mode, GAP);
        ref_mem[a] = d; ref_ok[a] = 1'b1;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] q; logic en;
        do_read(a, GAP, q, en);
        chk(en === 1'b1, req, en, 1);
        if (ref_ok[a]) chk(q === ref_mem[a], req, q, ref_mem[a]);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        if (!done) $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [DW-1:0] q; logic en; int e0;
        for (int i = 0; i < (1 << AW); i++) ref_ok[i] = 1'b0;
        void'($urandom(32'h1357));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rdata_oe === 1'b0, "R9 oe", rdata_oe, 0);
        chk(cyc_err === 1'b0, "R9 err", cyc_err, 0);
        repeat (GAP) @(negedge clk);

        // R3/R6: each closing edge commits
        wr_model(6'd5, 8'hA5, 0); rd_check(6'd5, "R3 strobe close");
        wr_model(6'd6, 8'h3B, 1); rd_check(6'd6, "R3 low select close");
        wr_model(6'd7, 8'hC4, 2); rd_check(6'd7, "R3 high select close");
        rd_check(6'd5, "R6 read");

        // R1: missing one write condition
        addr = 6'd5; wdata = 8'h00; we_n = 1'b0; cs_n = 1'b0; cs = 1'b0;
        repeat (6) @(negedge clk); go_idle(); repeat (GAP) @(negedge clk);
        rd_check(6'd5, "R1 no high select");
        addr = 6'd6; wdata = 8'h00; we_n = 1'b0; cs_n = 1'b1; cs = 1'b1;
        repeat (6) @(negedge clk); go_idle(); repeat (GAP) @(negedge clk);
        rd_check(6'd6, "R1 no low select");

        // R2: address moves mid-write
        wr_model(6'd11, 8'h44, 0);
        addr = 6'd10; wdata = 8'h3C; we_n = 1'b0; cs_n = 1'b0; cs = 1'b1;
        repeat (6) @(negedge clk); addr = 6'd11;
        repeat (6) @(negedge clk); we_n = 1'b1;
        @(negedge clk); go_idle(); repeat (GAP) @(negedge clk);
        ref_mem[10] = 8'h3C; ref_ok[10] = 1'b1;
        rd_check(6'd10, "R2 start address");
        rd_check(6'd11, "R2 later address ignored");

        // R4: data changes mid-write, last value kept
        addr = 6'd12; wdata = 8'h11; we_n = 1'b0; cs_n = 1'b0; cs = 1'b1;
        repeat (4) @(negedge clk); wdata = 8'h77;
        repeat (4) @(negedge clk); cs_n = 1'b1;
        @(negedge clk); go_idle(); repeat (GAP) @(negedge clk);
        ref_mem[12] = 8'h77; ref_ok[12] = 1'b1;
        rd_check(6'd12, "R4 last data");

        // R5: strobe during read
        wr_model(6'd20, 8'h5A, 0);
        addr = 6'd20; cs_n = 1'b0; cs = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rdata_oe === 1'b1 && rdata === 8'h5A, "R5 read before strobe", rdata, 8'h5A);
        wdata = 8'hC3; we_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rdata_oe === 1'b0, "R5 strobe turns bus off", rdata_oe, 0);
        repeat (3) @(negedge clk); we_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rdata_oe === 1'b1 && rdata === 8'hC3, "R5 write landed", rdata, 8'hC3);
        go_idle(); repeat (GAP) @(negedge clk);
        ref_mem[20] = 8'hC3;

        // R7: lock held
        prot = 1'b1; repeat (4) @(negedge clk);
        do_write(6'd5, 8'hEE, 0, GAP);
        do_read(6'd5, GAP, q, en);
        chk(en === 1'b0, "R7 lock no drive", en, 0);
        prot = 1'b0; repeat (4) @(negedge clk);
        rd_check(6'd5, "R7 locked write dropped");
        // R7: lock rises mid-write
        addr = 6'd6; wdata = 8'hDD; we_n = 1'b0; cs_n = 1'b0; cs = 1'b1;
        repeat (4) @(negedge clk); prot = 1'b1;
        repeat (4) @(negedge clk); we_n = 1'b1;
        @(negedge clk); go_idle(); repeat (GAP) @(negedge clk);
        prot = 1'b0; repeat (4) @(negedge clk);
        rd_check(6'd6, "R7 write aborted by lock");

        // R8: recovery window boundaries
        e0 = err_total;
        do_write(6'd30, 8'h10, 0, 1);
        do_write(6'd31, 8'h99, 0, GAP);
        ref_mem[30] = 8'h10; ref_ok[30] = 1'b1;
        chk((err_total - e0 == 1) == err_expected(1), "R8 gap 1 flagged", err_total - e0, 1);
        rd_check(6'd30, "R8 first write kept");
        do_read(6'd31, GAP, q, en);
        chk(en === 1'b1 && q !== 8'h99, "R8 rejected write", q, 0);
        e0 = err_total;
        do_write(6'd32, 8'h21, 0, REC);
        do_write(6'd33, 8'h22, 0, GAP);
        ref_mem[32] = 8'h21; ref_ok[32] = 1'b1;
        chk((err_total - e0 == 1) == err_expected(REC), "R8 gap REC flagged", err_total - e0, 1);
        e0 = err_total;
        do_write(6'd34, 8'h23, 0, REC + 1);
        do_write(6'd35, 8'h24, 0, GAP);
        ref_mem[34] = 8'h23; ref_ok[34] = 1'b1;
        ref_mem[35] = 8'h24; ref_ok[35] = 1'b1;
        chk((err_total - e0 == 0) == !err_expected(REC + 1), "R8 gap REC+1 clean", err_total - e0, 0);
        rd_check(6'd35, "R8 write after full recovery");
        e0 = err_total;
        do_write(6'd36, 8'h25, 0, 1);
        do_read(6'd36, GAP, q, en);
        chk(en === 1'b0, "R8 rejected read no drive", en, 0);
        chk(err_total - e0 == 1, "R8 read flagged", err_total - e0, 1);
        ref_mem[36] = 8'h25; ref_ok[36] = 1'b1;

        // random mix
        for (int i = 0; i < 150; i++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, (1 << AW) - 1));
            if ($urandom_range(0, 1) == 0)
                wr_model(ra, DW'($urandom), int'($urandom_range(0, 2)));
            else
                rd_check(ra, "R6 random read");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule